// File: doc/BRIEF.md
# Audio Sample FIFO Controller

This block holds the transmit and receive sample FIFOs of an audio serial port and manages the flow of samples between the system bus side and the serializer side. The bus side pushes outgoing samples into the transmit FIFO and pops incoming samples from the receive FIFO. The serializer side consumes transmit samples and delivers receive samples. The block reports both fill levels. It raises a DMA request per direction against a programmable level, and raises threshold status per direction against a second programmable value. It flags a transmit underrun and a receive overrun. Both flags are sticky and can be enabled onto a single interrupt line.

A small set of register-style inputs controls it. Level and threshold fields hold the intended value minus one. A start write loads both direction-run bits at once. A clear write flushes one or both FIFOs. The clear busy bit for each direction reads high until its flush has run a fixed number of cycles, and then drops by itself. Acknowledge writes remove the sticky flags, one bit per flag.

Top module: `audioFifoCtrl`

## Requirements
- R1: After reset both fill levels are 0, the start bits, clear-busy bits, underrun flag, overrun flag and interrupt are 0, and a DMA request is low while its enable is low.
- R2: Each bus push into a non-full transmit FIFO raises txLevel by one. While started, each serializer pop from a non-empty transmit FIFO lowers it by one. txSample always shows the oldest stored sample. A push when txLevel equals DEPTH is dropped.
- R3: txDmaReq is high exactly when txDmaEn is 1 and txLevel is at most txDmaLvl+1.
- R4: rxDmaReq is high exactly when rxDmaEn is 1 and rxLevel is greater than rxDmaLvl+1.
- R5: A startWr loads startData into startState, with bit 0 for transmit and bit 1 for receive. While a direction's bit is 0, its serializer-side pops or pushes change no level and set no flag.
- R6: A clrWr with clrData bit 0 (transmit) or bit 1 (receive) sets that clrBusy bit from the next cycle for exactly CLR_CYCLES cycles. The FIFO reads empty when the bit drops, and pushes made while busy are dropped.
- R7: A started serializer pop from an empty transmit FIFO sets underrunFlag on the next cycle. The flag stays set until an ackWr with ackData bit 0. A new set in the same cycle as an acknowledge wins.
- R8: A started serializer push into a full receive FIFO sets overrunFlag on the next cycle and drops the sample. The flag stays set until an ackWr with ackData bit 1. Bus pops remove receive samples in arrival order.
- R9: txLowStat is high exactly when txLevel is at most txThr+1. rxHighStat is high exactly when rxLevel is greater than rxThr+1.
- R10: irq equals (underrunFlag AND underrunIe) OR (overrunFlag AND overrunIe).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txDmaEn | input | 1 | Transmit DMA request enable |
| txDmaLvl | input | FLD_W | Transmit DMA level minus one |
| rxDmaEn | input | 1 | Receive DMA request enable |
| rxDmaLvl | input | FLD_W | Receive DMA level minus one |
| txThr | input | FLD_W | Transmit threshold minus one |
| rxThr | input | FLD_W | Receive threshold minus one |
| underrunIe | input | 1 | Underrun interrupt enable |
| overrunIe | input | 1 | Overrun interrupt enable |
| startWr | input | 1 | Write strobe for the start bits |
| startData | input | 2 | Start bits, bit 0 transmit, bit 1 receive |
| clrWr | input | 1 | Write strobe for the clear bits |
| clrData | input | 2 | Clear request, bit 0 transmit, bit 1 receive |
| ackWr | input | 1 | Write strobe for flag acknowledge |
| ackData | input | 2 | Acknowledge, bit 0 underrun, bit 1 overrun |
| txPush | input | 1 | Bus pushes a transmit sample |
| txData | input | DW | Transmit sample from the bus |
| txPop | input | 1 | Serializer requests a transmit sample |
| txSample | output | DW | Oldest transmit sample |
| rxPush | input | 1 | Serializer delivers a receive sample |
| rxSample | input | DW | Receive sample from the serializer |
| rxPop | input | 1 | Bus pops a receive sample |
| rxData | output | DW | Oldest receive sample |
| txLevel | output | $clog2(DEPTH)+1 | Transmit fill level |
| rxLevel | output | $clog2(DEPTH)+1 | Receive fill level |
| txDmaReq | output | 1 | Transmit DMA request |
| rxDmaReq | output | 1 | Receive DMA request |
| txLowStat | output | 1 | Transmit level at or below threshold |
| rxHighStat | output | 1 | Receive level above threshold |
| startState | output | 2 | Current start bits |
| clrBusy | output | 2 | Clear in progress, bit 0 transmit, bit 1 receive |
| underrunFlag | output | 1 | Sticky transmit underrun |
| overrunFlag | output | 1 | Sticky receive overrun |
| irq | output | 1 | Interrupt |

## Verification
The assertions assume that the bus and the serializer hold their strobes as single-cycle, synchronous pulses sampled at the rising edge. They also assume that the data inputs are valid whenever the matching push strobe is high. No other ordering is assumed: a pop from an empty FIFO, a push into a full one, and a clear or start rewrite in the middle of traffic are all legal inputs. The stimulus drives every input just after the falling edge. It mixes fill-heavy, drain-heavy and balanced phases, so both FIFOs reach their full and empty boundaries, and it scatters clears, start rewrites and acknowledges across those phases.

// File: rtl/afcPkg.sv
package afcPkg;
  timeunit 1ns;
  timeprecision 1ps;

  // Strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic txWrite;
    logic txRead;
    logic txFlush;
    logic rxWrite;
    logic rxRead;
    logic rxFlush;
  } afcStrobes_t;
endpackage

// File: rtl/afcFifo.sv
module afcFifo #(
  parameter int DW    = 24,
  parameter int DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       flush,
  input  logic                       wrEn,
  input  logic [DW-1:0]              wrData,
  input  logic                       rdEn,
  output logic [DW-1:0]              rdData,
  output logic [$clog2(DEPTH):0]     level,
  output logic                       empty,
  output logic                       full
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (wrEn) wrPtr <= wrPtr + AW'(1);
      if (rdEn) rdPtr <= rdPtr + AW'(1);
      case ({wrEn, rdEn})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end

  assign rdData = mem[rdPtr];
  assign empty  = (level == '0);
  assign full   = (level == LW'(DEPTH));

  a_r2_level_step: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !rdEn && !flush) |=> level == $past(level) + LW'(1));
  a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> level == '0);
endmodule

// File: rtl/afcDatapath.sv
module afcDatapath
  import afcPkg::*;
#(
  parameter int DW    = 24,
  parameter int DEPTH = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  afcStrobes_t            strb,
  input  logic [DW-1:0]          txData,
  output logic [DW-1:0]          txSample,
  input  logic [DW-1:0]          rxSample,
  output logic [DW-1:0]          rxData,
  output logic [$clog2(DEPTH):0] txLevel,
  output logic [$clog2(DEPTH):0] rxLevel,
  output logic                   txEmpty,
  output logic                   txFull,
  output logic                   rxEmpty,
  output logic                   rxFull
);
  timeunit 1ns;
  timeprecision 1ps;

  afcFifo #(.DW(DW), .DEPTH(DEPTH)) i_txFifo (
    .clk(clk), .rstN(rstN), .flush(strb.txFlush),
    .wrEn(strb.txWrite), .wrData(txData),
    .rdEn(strb.txRead), .rdData(txSample),
    .level(txLevel), .empty(txEmpty), .full(txFull));

  afcFifo #(.DW(DW), .DEPTH(DEPTH)) i_rxFifo (
    .clk(clk), .rstN(rstN), .flush(strb.rxFlush),
    .wrEn(strb.rxWrite), .wrData(rxSample),
    .rdEn(strb.rxRead), .rdData(rxData),
    .level(rxLevel), .empty(rxEmpty), .full(rxFull));
endmodule

// File: rtl/afcControl.sv
module afcControl
  import afcPkg::*;
#(
  parameter int DEPTH      = 32,
  parameter int FLD_W      = 5,
  parameter int CLR_CYCLES = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   txDmaEn,
  input  logic [FLD_W-1:0]       txDmaLvl,
  input  logic                   rxDmaEn,
  input  logic [FLD_W-1:0]       rxDmaLvl,
  input  logic [FLD_W-1:0]       txThr,
  input  logic [FLD_W-1:0]       rxThr,
  input  logic                   underrunIe,
  input  logic                   overrunIe,
  input  logic                   startWr,
  input  logic [1:0]             startData,
  input  logic                   clrWr,
  input  logic [1:0]             clrData,
  input  logic                   ackWr,
  input  logic [1:0]             ackData,
  input  logic                   txPush,
  input  logic                   txPop,
  input  logic                   rxPush,
  input  logic                   rxPop,
  input  logic [$clog2(DEPTH):0] txLevel,
  input  logic [$clog2(DEPTH):0] rxLevel,
  input  logic                   txEmpty,
  input  logic                   txFull,
  input  logic                   rxEmpty,
  input  logic                   rxFull,
  output afcStrobes_t            strb,
  output logic                   txDmaReq,
  output logic                   rxDmaReq,
  output logic                   txLowStat,
  output logic                   rxHighStat,
  output logic [1:0]             startState,
  output logic [1:0]             clrBusy,
  output logic                   underrunFlag,
  output logic                   overrunFlag,
  output logic                   irq
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CW = $clog2(CLR_CYCLES + 1);

  // One flush counter per direction, bit 0 transmit, bit 1 receive
  for (genvar d = 0; d < 2; d++) begin : g_clr
    logic [CW-1:0] clrCnt;
    always_ff @(posedge clk) begin
      if (!rstN)                   clrCnt <= '0;
      else if (clrWr && clrData[d]) clrCnt <= CW'(CLR_CYCLES);
      else if (clrCnt != '0)       clrCnt <= clrCnt - CW'(1);
    end
    assign clrBusy[d] = (clrCnt != '0);
  end

  logic underrunSet, overrunSet;
  assign underrunSet = txPop && startState[0] && txEmpty;
  assign overrunSet  = rxPush && startState[1] && rxFull;

  always_comb begin
    strb.txFlush = clrBusy[0];
    strb.rxFlush = clrBusy[1];
    strb.txWrite = txPush && !txFull && !clrBusy[0];
    strb.txRead  = txPop && startState[0] && !txEmpty && !clrBusy[0];
    strb.rxWrite = rxPush && startState[1] && !rxFull && !clrBusy[1];
    strb.rxRead  = rxPop && !rxEmpty && !clrBusy[1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startState   <= 2'b00;
      underrunFlag <= 1'b0;
      overrunFlag  <= 1'b0;
    end else begin
      if (startWr) startState <= startData;
      if (underrunSet)                underrunFlag <= 1'b1;
      else if (ackWr && ackData[0])   underrunFlag <= 1'b0;
      if (overrunSet)                 overrunFlag <= 1'b1;
      else if (ackWr && ackData[1])   overrunFlag <= 1'b0;
    end
  end

  // Fields hold value minus one
  assign txDmaReq   = txDmaEn && (int'(txLevel) <= int'(txDmaLvl) + 1);
  assign rxDmaReq   = rxDmaEn && (int'(rxLevel) >  int'(rxDmaLvl) + 1);
  assign txLowStat  = (int'(txLevel) <= int'(txThr) + 1);
  assign rxHighStat = (int'(rxLevel) >  int'(rxThr) + 1);
  assign irq = (underrunFlag && underrunIe) || (overrunFlag && overrunIe);

  a_r6_clear_starts: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && clrData[0]) |=> clrBusy[0]);
  a_r7_underrun_sets: assert property (@(posedge clk) disable iff (!rstN)
    (txPop && startState[0] && txEmpty) |=> underrunFlag);
  a_r7_underrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (underrunFlag && !(ackWr && ackData[0])) |=> underrunFlag);
  a_r8_overrun_sets: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && startState[1] && rxFull) |=> overrunFlag);
  a_r5_stopped_rx_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!startState[1] && !rxPop && !clrBusy[1]) |=> rxLevel == $past(rxLevel));
endmodule

// File: rtl/audioFifoCtrl.sv
module audioFifoCtrl
  import afcPkg::*;
#(
  parameter int DW         = 24,
  parameter int DEPTH      = 32,
  parameter int FLD_W      = 5,
  parameter int CLR_CYCLES = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   txDmaEn,
  input  logic [FLD_W-1:0]       txDmaLvl,
  input  logic                   rxDmaEn,
  input  logic [FLD_W-1:0]       rxDmaLvl,
  input  logic [FLD_W-1:0]       txThr,
  input  logic [FLD_W-1:0]       rxThr,
  input  logic                   underrunIe,
  input  logic                   overrunIe,
  input  logic                   startWr,
  input  logic [1:0]             startData,
  input  logic                   clrWr,
  input  logic [1:0]             clrData,
  input  logic                   ackWr,
  input  logic [1:0]             ackData,
  input  logic                   txPush,
  input  logic [DW-1:0]          txData,
  input  logic                   txPop,
  output logic [DW-1:0]          txSample,
  input  logic                   rxPush,
  input  logic [DW-1:0]          rxSample,
  input  logic                   rxPop,
  output logic [DW-1:0]          rxData,
  output logic [$clog2(DEPTH):0] txLevel,
  output logic [$clog2(DEPTH):0] rxLevel,
  output logic                   txDmaReq,
  output logic                   rxDmaReq,
  output logic                   txLowStat,
  output logic                   rxHighStat,
  output logic [1:0]             startState,
  output logic [1:0]             clrBusy,
  output logic                   underrunFlag,
  output logic                   overrunFlag,
  output logic                   irq
);
  timeunit 1ns;
  timeprecision 1ps;

  afcStrobes_t strb;
  logic txEmpty, txFull, rxEmpty, rxFull;

  afcControl #(.DEPTH(DEPTH), .FLD_W(FLD_W), .CLR_CYCLES(CLR_CYCLES)) i_control (
    .clk(clk), .rstN(rstN),
    .txDmaEn(txDmaEn), .txDmaLvl(txDmaLvl), .rxDmaEn(rxDmaEn), .rxDmaLvl(rxDmaLvl),
    .txThr(txThr), .rxThr(rxThr), .underrunIe(underrunIe), .overrunIe(overrunIe),
    .startWr(startWr), .startData(startData), .clrWr(clrWr), .clrData(clrData),
    .ackWr(ackWr), .ackData(ackData),
    .txPush(txPush), .txPop(txPop), .rxPush(rxPush), .rxPop(rxPop),
    .txLevel(txLevel), .rxLevel(rxLevel),
    .txEmpty(txEmpty), .txFull(txFull), .rxEmpty(rxEmpty), .rxFull(rxFull),
    .strb(strb), .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq),
    .txLowStat(txLowStat), .rxHighStat(rxHighStat),
    .startState(startState), .clrBusy(clrBusy),
    .underrunFlag(underrunFlag), .overrunFlag(overrunFlag), .irq(irq));

  afcDatapath #(.DW(DW), .DEPTH(DEPTH)) i_datapath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .txData(txData), .txSample(txSample), .rxSample(rxSample), .rxData(rxData),
    .txLevel(txLevel), .rxLevel(rxLevel),
    .txEmpty(txEmpty), .txFull(txFull), .rxEmpty(rxEmpty), .rxFull(rxFull));
endmodule

// File: tb/test_audioFifoCtrl.sv
module test_audioFifoCtrl;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DW = 24, DEPTH = 32, FLD_W = 5, CLR_CYCLES = 4;
  localparam int LW = $clog2(DEPTH) + 1;

  logic clk = 1'b0, rstN = 1'b0;
  logic txDmaEn = 0, rxDmaEn = 0, underrunIe = 0, overrunIe = 0;
  logic [FLD_W-1:0] txDmaLvl = 0, rxDmaLvl = 0, txThr = 0, rxThr = 0;
  logic startWr = 0, clrWr = 0, ackWr = 0;
  logic [1:0] startData = 0, clrData = 0, ackData = 0;
  logic txPush = 0, txPop = 0, rxPush = 0, rxPop = 0;
  logic [DW-1:0] txData = 0, rxSample = 0;
  logic [DW-1:0] txSample, rxData;
  logic [LW-1:0] txLevel, rxLevel;
  logic txDmaReq, rxDmaReq, txLowStat, rxHighStat, underrunFlag, overrunFlag, irq;
  logic [1:0] startState, clrBusy;

  audioFifoCtrl #(.DW(DW), .DEPTH(DEPTH), .FLD_W(FLD_W), .CLR_CYCLES(CLR_CYCLES)) i_audioFifoCtrl (
    .clk(clk), .rstN(rstN), .txDmaEn(txDmaEn), .txDmaLvl(txDmaLvl),
    .rxDmaEn(rxDmaEn), .rxDmaLvl(rxDmaLvl), .txThr(txThr), .rxThr(rxThr),
    .underrunIe(underrunIe), .overrunIe(overrunIe),
    .startWr(startWr), .startData(startData), .clrWr(clrWr), .clrData(clrData),
    .ackWr(ackWr), .ackData(ackData), .txPush(txPush), .txData(txData),
    .txPop(txPop), .txSample(txSample), .rxPush(rxPush), .rxSample(rxSample),
    .rxPop(rxPop), .rxData(rxData), .txLevel(txLevel), .rxLevel(rxLevel),
    .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq), .txLowStat(txLowStat),
    .rxHighStat(rxHighStat), .startState(startState), .clrBusy(clrBusy),
    .underrunFlag(underrunFlag), .overrunFlag(overrunFlag), .irq(irq));

  always #5 clk = ~clk;  // 100 MHz

  int checks = 0, fails = 0;
  bit done = 0;

  // Reference state
  logic [DW-1:0] txQ[$], rxQ[$];
  logic [1:0] mStart = 0;
  int cnt0 = 0, cnt1 = 0;
  bit mUnder = 0, mOver = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit expTxReq(int lvl);
    return txDmaEn && (lvl <= int'(txDmaLvl) + 1);
  endfunction
  function automatic bit expRxReq(int lvl);
    return rxDmaEn && (lvl > int'(rxDmaLvl) + 1);
  endfunction

  task automatic checkAll();
    chk(txLevel == LW'(txQ.size()), "R2 txLevel", txLevel, txQ.size());
    chk(rxLevel == LW'(rxQ.size()), "R8 rxLevel", rxLevel, rxQ.size());
    if (txQ.size() > 0) chk(txSample == txQ[0], "R2 txSample order", txSample, txQ[0]);
    if (rxQ.size() > 0) chk(rxData == rxQ[0], "R8 rxData order", rxData, rxQ[0]);
    chk(txDmaReq == expTxReq(txQ.size()), "R3 txDmaReq", txDmaReq, expTxReq(txQ.size()));
    chk(rxDmaReq == expRxReq(rxQ.size()), "R4 rxDmaReq", rxDmaReq, expRxReq(rxQ.size()));
    chk(txLowStat == (txQ.size() <= int'(txThr) + 1), "R9 txLowStat", txLowStat, txQ.size() <= int'(txThr) + 1);
    chk(rxHighStat == (rxQ.size() > int'(rxThr) + 1), "R9 rxHighStat", rxHighStat, rxQ.size() > int'(rxThr) + 1);
    chk(startState == mStart, "R5 startState", startState, mStart);
    chk(clrBusy == {cnt1 > 0, cnt0 > 0}, "R6 clrBusy", clrBusy, {cnt1 > 0, cnt0 > 0});
    chk(underrunFlag == mUnder, "R7 underrunFlag", underrunFlag, mUnder);
    chk(overrunFlag == mOver, "R8 overrunFlag", overrunFlag, mOver);
    chk(irq == ((mUnder && underrunIe) || (mOver && overrunIe)), "R10 irq", irq,
        (mUnder && underrunIe) || (mOver && overrunIe));
  endtask

  // Advance the reference by one clock edge using the held inputs
  task automatic stepModel();
    bit f0 = cnt0 > 0, f1 = cnt1 > 0;
    bit uSet = txPop && mStart[0] && txQ.size() == 0;
    bit oSet = rxPush && mStart[1] && rxQ.size() == DEPTH;
    if (f0) txQ.delete();
    else begin
      bit rd = txPop && mStart[0] && txQ.size() > 0;
      bit wr = txPush && txQ.size() < DEPTH;
      if (rd) void'(txQ.pop_front());
      if (wr) txQ.push_back(txData);
    end
    if (f1) rxQ.delete();
    else begin
      bit rd = rxPop && rxQ.size() > 0;
      bit wr = rxPush && mStart[1] && rxQ.size() < DEPTH;
      if (rd) void'(rxQ.pop_front());
      if (wr) rxQ.push_back(rxSample);
    end
    if (ackWr && ackData[0]) mUnder = 0;
    if (uSet) mUnder = 1;
    if (ackWr && ackData[1]) mOver = 0;
    if (oSet) mOver = 1;
    if (startWr) mStart = startData;
    if (clrWr && clrData[0]) cnt0 = CLR_CYCLES; else if (cnt0 > 0) cnt0--;
    if (clrWr && clrData[1]) cnt1 = CLR_CYCLES; else if (cnt1 > 0) cnt1--;
  endtask

  task automatic runPhase(int n, int pTxPush, int pTxPop, int pRxPush, int pRxPop);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      txPush = ($urandom % 100) < pTxPush;
      txPop  = ($urandom % 100) < pTxPop;
      rxPush = ($urandom % 100) < pRxPush;
      rxPop  = ($urandom % 100) < pRxPop;
      txData = DW'($urandom);
      rxSample = DW'($urandom);
      startWr = ($urandom % 100) < 3;
      startData = (($urandom % 4) == 0) ? 2'($urandom) : 2'b11;
      clrWr = ($urandom % 100) < 1;
      clrData = 2'($urandom);
      ackWr = ($urandom % 100) < 5;
      ackData = 2'($urandom);
      if (($urandom % 50) == 0) begin
        txDmaEn = 1'($urandom); rxDmaEn = 1'($urandom);
        txDmaLvl = FLD_W'($urandom); rxDmaLvl = FLD_W'($urandom);
        txThr = FLD_W'($urandom); rxThr = FLD_W'($urandom);
        underrunIe = 1'($urandom); overrunIe = 1'($urandom);
      end
      #1 checkAll();
      stepModel();
    end
  endtask

  // Directed cycle with explicit inputs
  task automatic drive(bit tPush, bit tPop, bit rPush, bit rPop, bit sWr, logic [1:0] sD,
                       bit cWr, logic [1:0] cD, bit aWr, logic [1:0] aD);
    @(negedge clk);
    txPush = tPush; txPop = tPop; rxPush = rPush; rxPop = rPop;
    txData = DW'($urandom); rxSample = DW'($urandom);
    startWr = sWr; startData = sD; clrWr = cWr; clrData = cD; ackWr = aWr; ackData = aD;
    #1 checkAll();
    stepModel();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    // R1: reset state
    chk(txLevel == 0 && rxLevel == 0, "R1 levels", {txLevel, rxLevel}, 0);
    chk(startState == 0 && clrBusy == 0, "R1 start/clear", {startState, clrBusy}, 0);
    chk(!underrunFlag && !overrunFlag && !irq, "R1 flags", {underrunFlag, overrunFlag, irq}, 0);
    chk(!txDmaReq && !rxDmaReq, "R1 dma low while disabled", {txDmaReq, rxDmaReq}, 0);

    // R5: stopped serializer side is ignored
    drive(0, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    drive(0, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    // R7: underrun from empty, set wins over ack, then ack clears
    drive(0, 0, 0, 0, 1, 2'b11, 0, 0, 0, 0);
    drive(0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    drive(0, 1, 0, 0, 0, 0, 0, 0, 1, 2'b01);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 2'b01);
    // R2/R8: fill both FIFOs past full, push overrun
    for (int k = 0; k < DEPTH + 3; k++) drive(1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    // R6: clear transmit mid-traffic, pushes during busy dropped
    drive(1, 0, 0, 0, 0, 0, 1, 2'b01, 0, 0);
    for (int k = 0; k < CLR_CYCLES + 2; k++) drive(1, 0, 0, 1, 0, 0, 0, 0, 0, 0);

    runPhase(600, 80, 20, 80, 20);
    runPhase(600, 20, 80, 20, 80);
    runPhase(600, 50, 50, 50, 50);
    runPhase(600, 95, 5, 95, 5);
    runPhase(600, 5, 95, 5, 95);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule